// File: doc/BRIEF.md
# Multi-Sample Key Code Debouncer

This block sits between a keypad encoder and the logic that consumes key presses. The encoder's raw code can chatter while a mechanical contact settles. The debouncer therefore takes samples only on a slow sampling tick, at roughly 10 Hz, so the sample spacing is longer than a typical 5–10 ms bounce. It keeps the last eight samples in a ring of history slots. A rotating write pointer picks the slot that each tick overwrites. A code is passed to the output only once every slot in the ring holds that same value.

When a newly agreed code differs from the code currently presented and is not the idle code `5'b11111`, a one-cycle strobe announces a fresh key. An agreed idle code updates the presented code without a strobe, so releasing a key re-arms detection of the same key.

A two-state controller tracks whether any key has been accepted since the last clear. State PRIMED is entered on clear and drives `none_yet` high. The transition PRIMED→ARMED is taken on the first fresh-key strobe. State ARMED holds until the next clear, and clear is the only transition back to PRIMED.

Top module: `keycode_debouncer`

## Requirements
- R1: While `clr` is high on a clock edge, `code_out` becomes `5'b11111` and `key_strobe` becomes 0. The eight history slots are seeded with the distinct values 0 through 7, so no agreement exists right after clear.
- R2: On each edge with `sample_tick` high, `raw_code` is written into the slot chosen by the write pointer, and the pointer advances by one. The pointer wraps from 7 to 0 and is 0 after clear.
- R3: On edges with `sample_tick` low, the history and the pointer are unchanged, and changes on `raw_code` have no effect on the outputs.
- R4: On the edge after all eight slots first hold the same value, `code_out` takes that value. `code_out` changes at no other time except clear.
- R5: `key_strobe` is high for exactly one cycle, on the same edge that `code_out` takes an agreed value that differs from the previous `code_out` and is not `5'b11111`. Repeated agreement on the current value raises no strobe.
- R6: An agreed value of `5'b11111` updates `code_out` but never raises `key_strobe`.
- R7: `none_yet` is high from clear until the first `key_strobe`. It goes low in the same cycle as that strobe and stays low until the next clear.
- R8: One sample that differs from the others blocks acceptance until a later tick overwrites that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| sample_tick | input | 1 | One-cycle sampling enable, about 10 Hz |
| raw_code | input | 5 | Undebounced key code, `5'b11111` when no key is pressed |
| code_out | output | 5 | Debounced key code |
| key_strobe | output | 1 | One-cycle pulse for a newly accepted key |
| none_yet | output | 1 | High while no key has been accepted since clear |

## Verification
A write pointer that skips or fails to wrap shows up at the ports as acceptance on the wrong tick. This is visible when a single bounced sample is injected: the strobe must appear exactly on the tick that overwrites that slot, and not one tick earlier or later. A history slot that loads during idle cycles shows up as a change of `code_out` after raw code changes with no tick. A controller stuck in the wrong state shows up in `none_yet` within one cycle of the first strobe or of a clear. A compare that ignores the last value shows up as repeated strobes for a held key.

// File: rtl/kdeb_pkg.sv
package kdeb_pkg;
    typedef enum logic [0:0] {
        ST_PRIMED = 1'b0,
        ST_ARMED  = 1'b1
    } kdeb_state_e;
endpackage

// File: rtl/kdeb_history.sv
module kdeb_history #(
    parameter int CODE_W = 5,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              tick,
    input  logic [CODE_W-1:0] raw_code,
    output logic              agree,
    output logic [CODE_W-1:0] agreed_code
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [CODE_W-1:0] slot [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [DEPTH-1:0]  match;

    // seeded with distinct values so clear cannot look like agreement
    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot[i] <= CODE_W'(i);
            end
            wr_idx <= '0;
        end else if (tick) begin
            slot[wr_idx] <= raw_code;
            wr_idx       <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
        end
    end

    assign match[0] = 1'b1;
    for (genvar g = 1; g < DEPTH; g++) begin : g_cmp
        assign match[g] = (slot[g] == slot[0]);
    end

    assign agree       = &match;
    assign agreed_code = slot[0];

    assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (clr)
        (tick && wr_idx == LAST_IDX) |=> (wr_idx == '0));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (clr)
        (tick && wr_idx != LAST_IDX) |=> (wr_idx == $past(wr_idx) + 1'b1));

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (clr)
        !tick |=> $stable(wr_idx));
endmodule

// File: rtl/kdeb_ctrl.sv
module kdeb_ctrl
    import kdeb_pkg::*;
#(
    parameter int              CODE_W    = 5,
    parameter logic [CODE_W-1:0] IDLE_CODE = '1
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              agree,
    input  logic [CODE_W-1:0] agreed_code,
    output logic [CODE_W-1:0] code_out,
    output logic              key_strobe,
    output logic              none_yet
);
    kdeb_state_e state_q, state_d;
    logic        fresh;

    assign fresh = agree && (agreed_code != code_out) && (agreed_code != IDLE_CODE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIMED: if (fresh) state_d = ST_ARMED;
            ST_ARMED:  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) state_q <= ST_PRIMED;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            code_out   <= IDLE_CODE;
            key_strobe <= 1'b0;
        end else begin
            if (agree) code_out <= agreed_code;
            key_strobe <= fresh;
        end
    end

    assign none_yet = (state_q == ST_PRIMED);

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (clr)
        key_strobe |=> !key_strobe);

    assert_strobe_not_idle_R6: assert property (@(posedge clk) disable iff (clr)
        key_strobe |-> (code_out != IDLE_CODE));

    assert_out_needs_agree_R4: assert property (@(posedge clk) disable iff (clr)
        !agree |=> $stable(code_out));

    assert_flag_after_strobe_R7: assert property (@(posedge clk) disable iff (clr)
        key_strobe |-> !none_yet);
endmodule

// File: rtl/keycode_debouncer.sv
module keycode_debouncer #(
    parameter int CODE_W = 5,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              sample_tick,
    input  logic [CODE_W-1:0] raw_code,
    output logic [CODE_W-1:0] code_out,
    output logic              key_strobe,
    output logic              none_yet
);
    logic              agree;
    logic [CODE_W-1:0] agreed_code;

    kdeb_history #(.CODE_W(CODE_W), .DEPTH(DEPTH)) hist_i (
        .clk         (clk),
        .clr         (clr),
        .tick        (sample_tick),
        .raw_code    (raw_code),
        .agree       (agree),
        .agreed_code (agreed_code)
    );

    kdeb_ctrl #(.CODE_W(CODE_W), .IDLE_CODE({CODE_W{1'b1}})) ctrl_i (
        .clk         (clk),
        .clr         (clr),
        .agree       (agree),
        .agreed_code (agreed_code),
        .code_out    (code_out),
        .key_strobe  (key_strobe),
        .none_yet    (none_yet)
    );
endmodule

// File: tb/keycode_debouncer_tb_top.sv
module keycode_debouncer_tb_top;
    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       sample_tick = 1'b0;
    logic [4:0] raw_code = 5'h1F;
    logic [4:0] code_out;
    logic       key_strobe;
    logic       none_yet;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    keycode_debouncer dut_i (
        .clk(clk), .clr(clr), .sample_tick(sample_tick), .raw_code(raw_code),
        .code_out(code_out), .key_strobe(key_strobe), .none_yet(none_yet)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one sample: tick at edge E, outputs settle at E+1, sampled after it
    task automatic push(input logic [4:0] c, output logic stb);
        @(negedge clk); raw_code = c; sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0;
        @(negedge clk); stb = key_strobe;
    endtask

    task automatic t_clear();
        @(negedge clk); clr = 1'b1;
        repeat (3) @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        check("R1 code_out after clear", code_out, 5'h1F);
        check("R1 strobe after clear", key_strobe, 0);
        check("R7 none_yet after clear", none_yet, 1);
    endtask

    task automatic t_guard();
        logic s;
        for (int i = 0; i < 7; i++) begin
            push(5'd3, s);
            check("R1 no early accept strobe", s, 0);
            check("R1 no early accept code", code_out, 5'h1F);
        end
        push(5'd3, s);
        check("R5 strobe on first accept", s, 1);
        check("R4 accepted code", code_out, 3);
        check("R7 none_yet drops with strobe", none_yet, 0);
        @(negedge clk);
        check("R5 strobe one cycle", key_strobe, 0);
    endtask

    task automatic t_repeat();
        logic s;
        int hits = 0;
        for (int i = 0; i < 8; i++) begin
            push(5'd3, s);
            hits += s;
        end
        check("R5 no strobe on same value", hits, 0);
        check("R4 code held", code_out, 3);
    endtask

    task automatic t_no_tick();
        logic s;
        int hits = 0;
        @(negedge clk); raw_code = 5'd9;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            raw_code = 5'(i);
            hits += key_strobe;
        end
        check("R3 code unchanged without tick", code_out, 3);
        check("R3 no strobe without tick", hits, 0);
        for (int i = 0; i < 7; i++) begin
            push(5'd9, s);
            hits += s;
        end
        check("R3 history kept, seven ticks not enough", hits, 0);
        push(5'd9, s);
        check("R4 accepted after eighth tick", code_out, 9);
        check("R5 strobe on new value", s, 1);
    endtask

    task automatic t_bounce();
        logic s;
        int hits = 0;
        push(5'd5, s); hits += s;
        push(5'd6, s); hits += s;
        for (int i = 0; i < 7; i++) begin
            push(5'd5, s);
            hits += s;
        end
        check("R8 bounced slot blocks accept", hits, 0);
        check("R8 code held while blocked", code_out, 9);
        push(5'd5, s);
        check("R2 strobe when wrapped pointer overwrites bounced slot", s, 1);
        check("R8 accepted after overwrite", code_out, 5);
    endtask

    task automatic t_idle();
        logic s;
        int hits = 0;
        for (int i = 0; i < 8; i++) begin
            push(5'h1F, s);
            hits += s;
        end
        check("R6 idle code accepted", code_out, 5'h1F);
        check("R6 no strobe for idle", hits, 0);
        for (int i = 0; i < 8; i++) push(5'd5, s);
        check("R5 same key strobes again after release", s, 1);
        check("R4 re-accepted code", code_out, 5);
    endtask

    task automatic t_reclear();
        logic s;
        int hits = 0;
        t_clear();
        for (int i = 0; i < 8; i++) begin
            push(5'h1F, s);
            hits += s;
        end
        check("R7 none_yet stays high on idle agreement", none_yet, 1);
        check("R6 no strobe on idle after clear", hits, 0);
    endtask

    initial begin
        t_clear();
        t_guard();
        t_repeat();
        t_no_tick();
        t_bounce();
        t_idle();
        t_reclear();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule